// File: doc/BRIEF.md
# Lockstep Mismatch Checker

This block is for a processor that can serve as the checking half of a master/checker lockstep pair. Both cores run the same program. The checker's pins are tied to the master's pins. When checking is active, the block compares every output bit that its own core would drive against the value seen on the shared pin, once per clock. Only bits whose output enable is set take part. Any difference produces an active-low error pulse.

The error pulse carries nothing but the fact that a mismatch occurred. It gives no error kind and no instruction. The block never stops or stalls anything; both cores keep running. Checking is switched on by a request input. Once on, only reset turns it off. A debug/probe-ready input blocks entry into checking and suspends the comparison while it is high.

Top module: `lockstep_checker`

## Requirements
- R1: With checking active and `dbg_i` low, a single cycle in which an enabled bit of `core_val_i` differs from `pin_val_i` drives `err_no` low for exactly one clock.
- R2: Inputs that mismatch at rising edge k drive `err_no` low from edge k+2 until edge k+3.
- R3: Mismatches at consecutive edges each give their own pulse, so `err_no` stays low for as many cycles as there were mismatching edges.
- R4: A bit takes part in the comparison only when its `core_oe_i` bit is 1. Differences on bits with enable 0 never lower `err_no`.
- R5: A mismatch changes nothing except `err_no`. Checking stays active, later matching cycles leave `err_no` high, and a later mismatch is reported again.
- R6: Checking becomes active at the first rising edge where `chk_req_i` is 1 and `dbg_i` is 0. Comparison applies from the following edge onward; a mismatch present at the entry edge itself is not reported.
- R7: Once active, checking stays active while `chk_req_i` is 0. Only `rst_ni` low ends it.
- R8: A `chk_req_i` of 1 has no effect at an edge where `dbg_i` is 1.
- R9: No mismatch is detected at an edge where `dbg_i` is 1, even with checking active.
- R10: `rst_ni` low clears checking mode and all pending pulses and forces `err_no` to 1 at once. While checking is inactive, `err_no` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_req_i | input | 1 | Request to enter checking mode |
| dbg_i | input | 1 | Debug / probe-ready indication |
| core_val_i | input | WIDTH | Values the local core would drive |
| core_oe_i | input | WIDTH | Per-bit output enable of the local core |
| pin_val_i | input | WIDTH | Values sampled on the shared pins |
| err_no | output | 1 | Mismatch pulse, active low |

## Verification
The assertions assume that `chk_req_i` and `dbg_i` are synchronous to `clk_i` and stable around each rising edge. They also assume that `rst_ni` is released away from an edge, so the two-edge latency relation is never observed across a reset. The stimulus changes every input only on the falling edge. Reset is asserted and released on falling edges, and err_no is read only after the pipeline has refilled. Debug assertion is applied both before and after checking mode is entered, so both the entry gate and the compare gate are exercised under the same assumptions.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  parameter int unsigned LSC_WIDTH_DEF = 32;
  // edges from detection register to visible pulse
  localparam int unsigned LSC_LAT = 2;

  typedef enum logic {
    MODE_IDLE  = 1'b0,
    MODE_CHECK = 1'b1
  } lsc_mode_e;
endpackage

// File: rtl/lsc_mode_latch.sv
module lsc_mode_latch
  import lsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_req_i,
  input  logic dbg_i,
  output logic mode_o
);
  lsc_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == MODE_IDLE && chk_req_i && !dbg_i) mode_d = MODE_CHECK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_IDLE;
    else         mode_q <= mode_d;
  end

  assign mode_o = (mode_q == MODE_CHECK);

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |=> mode_o);
  // R8
  req_in_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && dbg_i) |=> !mode_o);
  // R6
  mode_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && chk_req_i && !dbg_i) |=> mode_o);
endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
  parameter int unsigned WIDTH = lsc_pkg::LSC_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             dbg_i,
  input  logic [WIDTH-1:0] core_val_i,
  input  logic [WIDTH-1:0] core_oe_i,
  input  logic [WIDTH-1:0] pin_val_i,
  output logic             det_o
);
  logic [WIDTH-1:0] bit_diff;
  logic             det_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // tri-stated bits are masked
    assign bit_diff[b] = core_oe_i[b] & (core_val_i[b] ^ pin_val_i[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) det_q <= 1'b0;
    else         det_q <= mode_i & ~dbg_i & (|bit_diff);
  end

  assign det_o = det_q;

  // R9
  no_det_in_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |=> !det_o);
  // R10
  no_det_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> !det_o);
  // R4
  masked_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((core_val_i & core_oe_i) == (pin_val_i & core_oe_i)) |=> !det_o);
endmodule

// File: rtl/lsc_err_pipe.sv
module lsc_err_pipe
  import lsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  output logic err_no
);
  logic [LSC_LAT-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[LSC_LAT-2:0], det_i};
  end

  assign err_no = ~stage_q[LSC_LAT-1];

  // R2
  err_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |=> ##1 !err_no);
  // R1
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_no) |-> $past(det_i, 2));
endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker #(
  parameter int unsigned WIDTH = lsc_pkg::LSC_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chk_req_i,
  input  logic             dbg_i,
  input  logic [WIDTH-1:0] core_val_i,
  input  logic [WIDTH-1:0] core_oe_i,
  input  logic [WIDTH-1:0] pin_val_i,
  output logic             err_no
);
  logic mode;
  logic det;

  lsc_mode_latch u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chk_req_i (chk_req_i),
    .dbg_i     (dbg_i),
    .mode_o    (mode)
  );

  lsc_compare #(.WIDTH(WIDTH)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .dbg_i      (dbg_i),
    .core_val_i (core_val_i),
    .core_oe_i  (core_oe_i),
    .pin_val_i  (pin_val_i),
    .det_o      (det)
  );

  lsc_err_pipe u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .det_i  (det),
    .err_no (err_no)
  );

  // R10
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> err_no);
  // R10
  always_comb begin
    if (!rst_ni) err_in_rst_chk: assert (err_no);
  end
endmodule

// File: tb/lockstep_checker_tb.sv
module lockstep_checker_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NSTEP = 15;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, dbg = 1'b0;
  logic [W-1:0] val = '0, oe = '0, pin = '0;
  logic err_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_checker #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .chk_req_i(req), .dbg_i(dbg),
    .core_val_i(val), .core_oe_i(oe), .pin_val_i(pin), .err_no(err_n)
  );

  // {req, dbg, val, oe, pin, expected mismatch}
  localparam logic [26:0] TBL [NSTEP] = '{
    {1'b0, 1'b0, 8'hAA, 8'hFF, 8'h55, 1'b0}, // R10 idle, no check
    {1'b1, 1'b1, 8'hAA, 8'hFF, 8'h55, 1'b0}, // R8 req during debug
    {1'b0, 1'b0, 8'hAA, 8'hFF, 8'h55, 1'b0}, // R8 still idle
    {1'b1, 1'b0, 8'hAA, 8'hFF, 8'h55, 1'b0}, // R6 entry edge not checked
    {1'b0, 1'b0, 8'hAA, 8'hFF, 8'hAA, 1'b0}, // R7 match
    {1'b0, 1'b0, 8'hAA, 8'hFF, 8'hAB, 1'b1}, // R1 single mismatch
    {1'b0, 1'b0, 8'h00, 8'h0F, 8'hF0, 1'b0}, // R4 masked difference
    {1'b0, 1'b0, 8'h01, 8'h01, 8'h00, 1'b1}, // R3 first of two
    {1'b0, 1'b0, 8'h01, 8'h01, 8'h00, 1'b1}, // R3 second of two
    {1'b0, 1'b1, 8'h01, 8'h01, 8'h00, 1'b0}, // R9 debug suspends check
    {1'b0, 1'b0, 8'h3C, 8'hFF, 8'h3C, 1'b0}, // R5 matches after error
    {1'b0, 1'b0, 8'h80, 8'h80, 8'h00, 1'b1}, // R5 reported again
    {1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string req_tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: err_no=%b expected %b at %0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [26:0] v);
    {req, dbg, val, oe, pin} = v[26:1];
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(err_n, 1'b1, "R10 reset state");
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: table walk, pulse seen 3 negedges after drive
    for (int j = 0; j < NSTEP + 3; j++) begin
      @(negedge clk);
      if (j >= 3) check(err_n, ~TBL[j-3][0], "R2 table");
      else        check(err_n, 1'b1, "R10 table head");
      if (j < NSTEP) drive(TBL[j]);
    end

    // R10: reset while a pulse is pending
    drive({1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 1'b1});
    @(negedge clk);
    drive({1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0});
    rst_ni = 1'b0;
    #1 check(err_n, 1'b1, "R10 async clear");
    @(negedge clk);
    rst_ni = 1'b1;
    // R10: mode cleared, mismatches now ignored
    drive({1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 1'b1});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(err_n, 1'b1, "R10 idle after reset");
    end

    // R6: enter again with debug low, mismatch on next edge reported
    drive({1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0});
    @(negedge clk);
    drive({1'b0, 1'b0, 8'h10, 8'h10, 8'h00, 1'b1});
    @(negedge clk);
    drive({1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0});
    @(negedge clk);
    check(err_n, 1'b1, "R2 not early");
    @(negedge clk);
    check(err_n, 1'b0, "R6 re-entry pulse");
    @(negedge clk);
    check(err_n, 1'b1, "R1 one clock only");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule